// File: doc/BRIEF.md
# Single-Slope Level Converter Controller

This block runs a ramp-and-compare measurement that turns an analog level into a number. An external capacitor charges through a resistor, and an external comparator checks it against the signal being measured. When a conversion is requested, the controller closes a discharge switch for a fixed number of clock cycles to empty the capacitor. It then opens the switch and counts clock cycles while the ramp rises. The count stops at the first cycle in which the comparator output differs from the level it had when the switch opened. The elapsed count is the measured level, so a higher input gives a larger count.

The comparator line is asynchronous to the clock, so it passes through a two-flop synchronizer before the controller compares it. If the comparator never changes, the counter stops at its top value and the result is reported as a timeout. Each finished conversion gives a one-cycle completion pulse. The result and the timeout flag stay unchanged until the next conversion finishes.

Top module: `ramp_level_conv`

## Requirements
- R1: While reset is applied and just after it is released, `dischg_o`, `done_o` and `timeout_o` are low and `level_o` is zero.
- R2: A high `start_i` sampled while idle makes `dischg_o` high for exactly DISCH_CYC consecutive cycles, starting in the cycle after the sampling edge.
- R3: Counting starts only once `dischg_o` has dropped. Call the first cycle in which `dischg_o` reads low cycle 0. If the comparator input changes in cycle n, the result `level_o` is n+2, where the 2 is the synchronizer latency.
- R4: Any change of the comparator input stops the count. Low to high and high to low both count, measured against the level the input held when the discharge ended.
- R5: `done_o` is high for exactly one cycle. When a comparator change ends the conversion, that cycle is the third cycle after the cycle in which the input changed.
- R6: If no change is seen before the count reaches 2^CNT_W-1, the conversion ends with `level_o` all ones and `timeout_o` high. A change that yields exactly 2^CNT_W-1 is a normal result with `timeout_o` low.
- R7: `level_o` and `timeout_o` change only in a cycle where `done_o` is high, and otherwise hold their value.
- R8: A `start_i` pulse during a conversion is ignored: `dischg_o` stays low and the result is the same as without the pulse.
- R9: Changes of the comparator input while the block is idle have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, sampled when idle |
| cmp_i | input | 1 | Asynchronous comparator output |
| dischg_o | output | 1 | Closes the capacitor discharge switch while high |
| level_o | output | CNT_W | Measured level of the most recent conversion |
| done_o | output | 1 | One-cycle pulse when a conversion finishes |
| timeout_o | output | 1 | The last conversion ended by saturation |

## Verification
The bench builds the block with CNT_W=8 and DISCH_CYC=5. With these values the counter saturates after 255 cycles, so timeouts and the last-count boundary (comparator change at n=253 versus no change at all) are reached in a few hundred cycles each. The short discharge keeps the many random conversions, in both comparator polarities and some with start pulses injected mid-count, well inside the run limit.

// File: rtl/ramp_conv_pkg.sv
package ramp_conv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISCH = 2'd1,
    ST_COUNT = 2'd2,
    ST_DONE  = 2'd3
  } conv_state_e;
endpackage

// File: rtl/ramp_rst_sync.sv
module ramp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ramp_cmp_sync.sv
module ramp_cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ramp_pulse_timer.sv
module ramp_pulse_timer #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  localparam int TW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [TW-1:0] tick_q, tick_d;
  logic          tick_en;

  always_comb begin
    tick_en = 1'b0;
    tick_d  = tick_q;
    if (run_i) begin
      tick_en = 1'b1;
      tick_d  = tick_q + TW'(1);
    end else if (tick_q != '0) begin
      tick_en = 1'b1;
      tick_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick_q <= '0;
    else if (tick_en) tick_q <= tick_d;
  end

  assign last_o = run_i && (tick_q == TW'(CYCLES - 1));
endmodule

// File: rtl/ramp_tick_counter.sv
module ramp_tick_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         full_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr_i || inc_i;
    cnt_d  = clr_i ? '0 : (cnt_q + W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign full_o = &cnt_q;
endmodule

// File: rtl/ramp_level_conv.sv
module ramp_level_conv
  import ramp_conv_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int DISCH_CYC = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             dischg_o,
  output logic [CNT_W-1:0] level_o,
  output logic             done_o,
  output logic             timeout_o
);
  logic              srst_n;
  logic              cmp_sync;
  logic              disch_last;
  logic [CNT_W-1:0]  tick_cnt;
  logic              tick_full;

  conv_state_e       state_q, state_d;
  logic              ref_q;
  logic [CNT_W-1:0]  level_q;
  logic              tout_q;

  logic              cnt_clr, cnt_inc, ref_load, res_load, res_tout;

  ramp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ramp_cmp_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk     (clk),
    .rst_n   (srst_n),
    .async_i (cmp_i),
    .sync_o  (cmp_sync)
  );

  ramp_pulse_timer #(.CYCLES(DISCH_CYC)) u_disch (
    .clk    (clk),
    .rst_n  (srst_n),
    .run_i  (state_q == ST_DISCH),
    .last_o (disch_last)
  );

  ramp_tick_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (srst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (tick_cnt),
    .full_o (tick_full)
  );

  // next-state and control decode
  always_comb begin
    state_d  = state_q;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    ref_load = 1'b0;
    res_load = 1'b0;
    res_tout = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_DISCH;
      end
      ST_DISCH: begin
        if (disch_last) begin
          state_d  = ST_COUNT;
          cnt_clr  = 1'b1;
          ref_load = 1'b1;
        end
      end
      ST_COUNT: begin
        if (cmp_sync != ref_q) begin
          state_d  = ST_DONE;
          res_load = 1'b1;
        end else if (tick_full) begin
          state_d  = ST_DONE;
          res_load = 1'b1;
          res_tout = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       ref_q <= 1'b0;
    else if (ref_load) ref_q <= cmp_sync;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      level_q <= '0;
      tout_q  <= 1'b0;
    end else if (res_load) begin
      level_q <= tick_cnt;
      tout_q  <= res_tout;
    end
  end

  assign dischg_o  = (state_q == ST_DISCH);
  assign done_o    = (state_q == ST_DONE);
  assign level_o   = level_q;
  assign timeout_o = tout_q;
endmodule

// File: rtl/ramp_level_conv_chk.sv
module ramp_level_conv_chk #(
  parameter int CNT_W     = 12,
  parameter int DISCH_CYC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             dischg_o,
  input logic [CNT_W-1:0] level_o,
  input logic             done_o,
  input logic             timeout_o
);
  localparam int HW = $clog2(DISCH_CYC + 2) + 1;

  logic [HW-1:0] high_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        high_run <= '0;
    else if (dischg_o) high_run <= high_run + HW'(1);
    else               high_run <= '0;
  end

  AST_DISCH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dischg_o) |-> (high_run == HW'(DISCH_CYC))); // R2

  AST_DISCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    high_run <= HW'(DISCH_CYC)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5

  AST_SAT_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timeout_o) |-> (level_o == {CNT_W{1'b1}})); // R6

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_o) |-> done_o); // R7

  AST_TIMEOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(timeout_o) |-> done_o); // R7

  AST_DISCH_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dischg_o) |-> $past(start_i)); // R8

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(dischg_o && done_o)); // R8
endmodule

bind ramp_level_conv ramp_level_conv_chk #(
  .CNT_W     (CNT_W),
  .DISCH_CYC (DISCH_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .dischg_o  (dischg_o),
  .level_o   (level_o),
  .done_o    (done_o),
  .timeout_o (timeout_o)
);

// File: tb/tb_ramp_level_conv.sv
`timescale 1ns/1ps
module tb_ramp_level_conv;
  localparam int CNT_W     = 8;
  localparam int DISCH_CYC = 5;
  localparam int MAXV      = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic             cmp_i;
  logic             dischg_o;
  logic [CNT_W-1:0] level_o;
  logic             done_o;
  logic             timeout_o;

  int checks;
  int failures;
  bit finished;

  ramp_level_conv #(.CNT_W(CNT_W), .DISCH_CYC(DISCH_CYC)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cmp_i     (cmp_i),
    .dischg_o  (dischg_o),
    .level_o   (level_o),
    .done_o    (done_o),
    .timeout_o (timeout_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int exp_level(int n);
    return (n + 2 > MAXV) ? MAXV : n + 2;
  endfunction

  function automatic bit exp_tout(int n);
    return (n + 2 > MAXV);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_conv(int n, bit pol, bit inj);
    int  hi;
    int  lat;
    bit  bad;
    int  lvl_seen;
    @(negedge clk);
    cmp_i   = pol;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    hi = 0;
    while (dischg_o && hi < DISCH_CYC + 4) begin
      hi++;
      @(negedge clk);
    end
    chk(hi == DISCH_CYC, "R2 discharge width", hi, DISCH_CYC);
    bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = inj && (n >= 4) && (i == n / 2);
      if (dischg_o) bad = 1'b1;
      if (done_o) break;
    end
    start_i = 1'b0;
    lat = 0;
    if (!exp_tout(n)) begin
      cmp_i = ~pol;
      while (!done_o && lat < 10) begin
        @(negedge clk);
        lat++;
        if (dischg_o) bad = 1'b1;
      end
      chk(lat == 3, "R5 done latency", lat, 3);
    end else begin
      while (!done_o && lat < 2 * MAXV) begin
        @(negedge clk);
        lat++;
        if (dischg_o) bad = 1'b1;
      end
    end
    if (inj) chk(!bad, "R8 start ignored mid-conversion", int'(bad), 0);
    chk(done_o == 1'b1, "R5 done seen", int'(done_o), 1);
    if (pol)
      chk(int'(level_o) == exp_level(n), "R4 level falling compare", int'(level_o), exp_level(n));
    else
      chk(int'(level_o) == exp_level(n), "R3 level rising compare", int'(level_o), exp_level(n));
    chk(timeout_o == exp_tout(n), "R6 timeout flag", int'(timeout_o), int'(exp_tout(n)));
    lvl_seen = int'(level_o);
    @(negedge clk);
    chk(done_o == 1'b0, "R5 done one cycle", int'(done_o), 0);
    chk(int'(level_o) == lvl_seen, "R7 level held", int'(level_o), lvl_seen);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    finished = 1'b0;
    void'($urandom(32'd7321));
    rst_n   = 1'b0;
    start_i = 1'b0;
    cmp_i   = 1'b0;
    repeat (3) @(negedge clk);
    chk(!dischg_o && !done_o && !timeout_o && level_o == '0, "R1 reset outputs",
        int'({dischg_o, done_o, timeout_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!dischg_o && !done_o && !timeout_o && level_o == '0, "R1 after release",
        int'(level_o), 0);

    // directed corners
    run_conv(0, 1'b0, 1'b0);
    run_conv(10, 1'b1, 1'b0);
    run_conv(MAXV - 2, 1'b0, 1'b0);   // exact top value, no timeout (R6)
    run_conv(MAXV - 1, 1'b0, 1'b0);   // one more: timeout (R6)
    run_conv(400, 1'b1, 1'b0);        // never changes: timeout
    run_conv(40, 1'b0, 1'b1);         // start mid-count (R8)

    // R9: comparator toggles while idle
    begin
      int lv;
      bit tf;
      bit moved;
      lv = int'(level_o);
      tf = timeout_o;
      moved = 1'b0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        cmp_i = ~cmp_i;
        if (dischg_o || done_o || int'(level_o) != lv || timeout_o != tf) moved = 1'b1;
      end
      chk(!moved, "R9 idle comparator ignored", int'(moved), 0);
    end

    // random conversions
    for (int r = 0; r < 24; r++) begin
      int  n;
      bit  pol;
      bit  inj;
      n   = int'($urandom_range(0, 300));
      pol = 1'($urandom_range(0, 1));
      inj = 1'($urandom_range(0, 1));
      run_conv(n, pol, inj);
      repeat (int'($urandom_range(0, 3))) @(negedge clk);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule